// File: doc/BRIEF.md
# Five-Phase Register ALU Core

This core runs one instruction at a time through five clock phases: fetch, decode, operand read, execute and write-back. A 14-bit opcode word and a 16-bit data word are presented at the inputs, and the core samples them in the fetch phase. The core holds eight 16-bit general registers, four condition flags, an eight-entry push/pop stack, and a forwarding register that keeps the most recent result.

Stores and jumps reach the outside world only during write-back. A store places an address and a data word on the memory buses. A jump places a target on the program-counter bus. In every other phase those buses are left undriven (high impedance). A halt instruction freezes the phase sequence until the next reset.

Top module: `alu5_core`

## Requirements
- R1: Phases run fetch, decode, read, execute, write-back and then wrap to fetch, one phase per clock. The opcode and data are sampled at the fetch edge. Results appear on the outputs in the fourth cycle after that edge, which is the write-back phase.
- R2: Opcode bits [13:6] hold the operation code, bits [5:3] hold register A (the destination and first source) and bits [2:0] hold register B. The codes are: 00 no-op, 01 AND, 02 OR, 03 XOR, 04 NOT, 05 NEG, 06 ADD, 07 MUL, 08 load-immediate, 09 PUSH, 0A POP, 0B STORE, 0C JUMP, 0D HALT.
- R3: There are eight registers, indexed 0 to 7. Load-immediate writes the data word into register A.
- R4: AND, OR and XOR write A op B into A. NOT writes ~A into A. None of these four changes the flags.
- R5: The flags output is {zero, carry, sign, overflow}, bits 3 down to 0. ADD writes A+B into A, with carry from the 17th sum bit and signed overflow. NEG writes 0-A into A, with carry set when A is nonzero and overflow set when A is 16'h8000. For both, zero and sign come from the 16-bit result.
- R6: MUL writes the low 16 bits of the unsigned product A*B into A. Carry and overflow are both set when the high 16 bits are nonzero. Zero and sign come from the low half.
- R7: PUSH saves A on the stack and POP restores the newest saved value into A, in last-in-first-out order. The stack holds 8 entries.
- R8: A PUSH on a full stack and a POP on an empty stack are ignored. The stack and register A are left unchanged.
- R9: During write-back, STORE drives the memory address with the data word and the store data with register A. In every other phase, and for every other instruction, both buses are high impedance.
- R10: During write-back, JUMP drives the data word onto the program-counter output. At all other times that output is high impedance.
- R11: HALT sets the halted output. After that, no instruction changes any state or drives any output until reset.
- R12: Reset is synchronous and active high. It clears the registers, flags, stack and halt state, and releases all three buses.
- R13: Undefined operation codes change no register, flag or stack state.
- R14: An instruction that reads a register written by the instruction just before it sees the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 14 | Operation code and register A/B indices |
| data | input | 16 | Immediate value, store address or jump target |
| mem_addr | output | 16 | Store address, high impedance when not storing |
| mem_wdata | output | 16 | Store data, high impedance when not storing |
| pc_target | output | 16 | Jump target, high impedance when not jumping |
| cond_flags | output | 4 | {zero, carry, sign, overflow} |
| halted | output | 1 | High once a HALT has completed |

## Verification
The assertions check several things on every clock. The phase always steps by one and wraps after write-back. Once halted, the core stays halted and the phase stays frozen. The stack pointer stays within bounds and does not move on an overflowing push or an underflowing pop. The flags change only at the execute edge. Every register-file write matches the forwarding register.

Other behaviour can only be shown by the bench scenarios. These cover the arithmetic values and flag encodings, the stack order, the bus timing and release, the no-effect cases after halt or an undefined code, and the read-after-write case. In each scenario the bench compares the outputs with an independent model.

// File: rtl/alu5_pkg.sv
package alu5_pkg;
    localparam int DATA_W   = 16;
    localparam int RADDR_W  = 3;
    localparam int NUM_REGS = 1 << RADDR_W;
    localparam int CODE_W   = 8;
    localparam int OPC_W    = CODE_W + 2 * RADDR_W;
    localparam int STK_DEPTH = 8;

    localparam logic [CODE_W-1:0] C_AND   = 8'h01;
    localparam logic [CODE_W-1:0] C_OR    = 8'h02;
    localparam logic [CODE_W-1:0] C_XOR   = 8'h03;
    localparam logic [CODE_W-1:0] C_NOT   = 8'h04;
    localparam logic [CODE_W-1:0] C_NEG   = 8'h05;
    localparam logic [CODE_W-1:0] C_ADD   = 8'h06;
    localparam logic [CODE_W-1:0] C_MUL   = 8'h07;
    localparam logic [CODE_W-1:0] C_LDI   = 8'h08;
    localparam logic [CODE_W-1:0] C_PUSH  = 8'h09;
    localparam logic [CODE_W-1:0] C_POP   = 8'h0A;
    localparam logic [CODE_W-1:0] C_STORE = 8'h0B;
    localparam logic [CODE_W-1:0] C_JUMP  = 8'h0C;
    localparam logic [CODE_W-1:0] C_HALT  = 8'h0D;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        PH_FETCH, PH_DECODE, PH_READ, PH_EXEC, PH_WB
    } phase_e;

    typedef enum logic [3:0] {
        K_NOP, K_AND, K_OR, K_XOR, K_NOT, K_NEG, K_ADD, K_MUL,
        K_LDI, K_PUSH, K_POP, K_STORE, K_JUMP, K_HALT
    } kind_e;

    typedef struct packed {
        logic [CODE_W-1:0]  code;
        logic [RADDR_W-1:0] ra;
        logic [RADDR_W-1:0] rb;
    } instr_t;

    typedef struct packed {
        logic z;
        logic c;
        logic s;
        logic o;
    } flags_t;

    typedef struct packed {
        word_t  value;
        logic   wr;
        flags_t flags;
    } exec_res_t;

    function automatic kind_e decode_code(input logic [CODE_W-1:0] code);
        case (code)
            C_AND:   return K_AND;
            C_OR:    return K_OR;
            C_XOR:   return K_XOR;
            C_NOT:   return K_NOT;
            C_NEG:   return K_NEG;
            C_ADD:   return K_ADD;
            C_MUL:   return K_MUL;
            C_LDI:   return K_LDI;
            C_PUSH:  return K_PUSH;
            C_POP:   return K_POP;
            C_STORE: return K_STORE;
            C_JUMP:  return K_JUMP;
            C_HALT:  return K_HALT;
            default: return K_NOP;
        endcase
    endfunction
endpackage

// File: rtl/alu5_phase_ctrl.sv
module alu5_phase_ctrl
    import alu5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   halt_set,
    output phase_e phase,
    output logic   halted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_FETCH;
            halted <= 1'b0;
        end else begin
            if (halt_set)
                halted <= 1'b1;
            if (!halted)
                phase <= (phase == PH_WB) ? PH_FETCH : phase_e'(phase + 3'd1);
        end
    end

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && phase != PH_WB) |=> (phase == phase_e'($past(phase) + 3'd1)));
    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WB) |=> (phase == PH_FETCH));
    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(phase)));
endmodule

// File: rtl/alu5_regfile.sv
module alu5_regfile
    import alu5_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fwd_load,
    input  logic [RADDR_W-1:0] fwd_idx_in,
    input  word_t              fwd_val_in,
    input  logic               wr_en,
    input  logic [RADDR_W-1:0] wr_idx,
    input  word_t              wr_val,
    input  logic [RADDR_W-1:0] rd_a_idx,
    input  logic [RADDR_W-1:0] rd_b_idx,
    output word_t              rd_a,
    output word_t              rd_b
);
    word_t              regs [NUM_REGS];
    logic               fwd_vld;
    logic [RADDR_W-1:0] fwd_idx;
    word_t              fwd_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
            fwd_vld <= 1'b0;
            fwd_idx <= '0;
            fwd_val <= '0;
        end else begin
            if (wr_en) regs[wr_idx] <= wr_val;
            if (fwd_load) begin
                fwd_vld <= 1'b1;
                fwd_idx <= fwd_idx_in;
                fwd_val <= fwd_val_in;
            end
        end
    end

    always_comb begin
        rd_a = (fwd_vld && fwd_idx == rd_a_idx) ? fwd_val : regs[rd_a_idx];
        rd_b = (fwd_vld && fwd_idx == rd_b_idx) ? fwd_val : regs[rd_b_idx];
    end

    // R14
    fwd_match_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (fwd_vld && fwd_idx == wr_idx && fwd_val == wr_val));
endmodule

// File: rtl/alu5_stack.sv
module alu5_stack
    import alu5_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  logic  pop,
    input  word_t push_val,
    output word_t pop_val,
    output logic  pop_ok
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = $clog2(DEPTH + 1);

    word_t             mem [DEPTH];
    logic [PTR_W-1:0]  sp;
    logic              full;

    assign full    = (sp == PTR_W'(DEPTH));
    assign pop_ok  = (sp != '0);
    assign pop_val = mem[IDX_W'(sp - PTR_W'(1))];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            sp <= '0;
        end else if (push && !full) begin
            mem[IDX_W'(sp)] <= push_val;
            sp <= sp + PTR_W'(1);
        end else if (pop && pop_ok) begin
            sp <= sp - PTR_W'(1);
        end
    end

    // R7
    sp_range_chk: assert property (@(posedge clk) disable iff (rst)
        sp <= PTR_W'(DEPTH));
    // R8
    push_full_chk: assert property (@(posedge clk) disable iff (rst)
        (push && sp == PTR_W'(DEPTH)) |=> $stable(sp));
    // R8
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && sp == '0) |=> $stable(sp));
endmodule

// File: rtl/alu5_exec.sv
module alu5_exec
    import alu5_pkg::*;
(
    input  kind_e     kind,
    input  word_t     a,
    input  word_t     b,
    input  word_t     d,
    input  word_t     stk_val,
    input  logic      stk_ok,
    input  flags_t    flags_in,
    output exec_res_t res
);
    logic [DATA_W:0]     sum;
    logic [2*DATA_W-1:0] prod;
    word_t               neg;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign prod = a * b;
    assign neg  = ~a + word_t'(1);

    always_comb begin
        res.value = a;
        res.wr    = 1'b0;
        res.flags = flags_in;
        case (kind)
            K_AND: begin res.value = a & b; res.wr = 1'b1; end
            K_OR:  begin res.value = a | b; res.wr = 1'b1; end
            K_XOR: begin res.value = a ^ b; res.wr = 1'b1; end
            K_NOT: begin res.value = ~a;    res.wr = 1'b1; end
            K_LDI: begin res.value = d;     res.wr = 1'b1; end
            K_POP: begin res.value = stk_val; res.wr = stk_ok; end
            K_ADD: begin
                res.value   = sum[DATA_W-1:0];
                res.wr      = 1'b1;
                res.flags.c = sum[DATA_W];
                res.flags.o = (a[DATA_W-1] == b[DATA_W-1]) &&
                              (sum[DATA_W-1] != a[DATA_W-1]);
            end
            K_NEG: begin
                res.value   = neg;
                res.wr      = 1'b1;
                res.flags.c = (a != '0);
                res.flags.o = (a == {1'b1, {(DATA_W-1){1'b0}}});
            end
            K_MUL: begin
                res.value   = prod[DATA_W-1:0];
                res.wr      = 1'b1;
                res.flags.c = |prod[2*DATA_W-1:DATA_W];
                res.flags.o = |prod[2*DATA_W-1:DATA_W];
            end
            default: ;
        endcase
        if (kind == K_ADD || kind == K_NEG || kind == K_MUL) begin
            res.flags.z = (res.value == '0);
            res.flags.s = res.value[DATA_W-1];
        end
    end
endmodule

// File: rtl/alu5_core.sv
module alu5_core
    import alu5_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [OPC_W-1:0]      opcode,
    input  logic [DATA_W-1:0]     data,
    output logic [DATA_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [DATA_W-1:0]     pc_target,
    output logic [3:0]            cond_flags,
    output logic                  halted
);
    phase_e    phase;
    instr_t    ir;
    word_t     dr;
    kind_e     kind_q;
    word_t     opa, opb, res_q;
    logic      wr_q;
    flags_t    flags_q;
    word_t     rd_a, rd_b, stk_val;
    logic      stk_ok;
    exec_res_t ex;
    logic      in_exec, in_wb;

    assign in_exec = (phase == PH_EXEC) && !halted;
    assign in_wb   = (phase == PH_WB) && !halted;

    alu5_phase_ctrl u_phase (
        .clk(clk), .rst(rst),
        .halt_set(in_wb && kind_q == K_HALT),
        .phase(phase), .halted(halted)
    );

    alu5_regfile u_rf (
        .clk(clk), .rst(rst),
        .fwd_load(in_exec && ex.wr), .fwd_idx_in(ir.ra), .fwd_val_in(ex.value),
        .wr_en(in_wb && wr_q), .wr_idx(ir.ra), .wr_val(res_q),
        .rd_a_idx(ir.ra), .rd_b_idx(ir.rb),
        .rd_a(rd_a), .rd_b(rd_b)
    );

    alu5_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk(clk), .rst(rst),
        .push(in_exec && kind_q == K_PUSH),
        .pop(in_exec && kind_q == K_POP),
        .push_val(opa), .pop_val(stk_val), .pop_ok(stk_ok)
    );

    alu5_exec u_exec (
        .kind(kind_q), .a(opa), .b(opb), .d(dr),
        .stk_val(stk_val), .stk_ok(stk_ok),
        .flags_in(flags_q), .res(ex)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir      <= '0;
            dr      <= '0;
            kind_q  <= K_NOP;
            opa     <= '0;
            opb     <= '0;
            res_q   <= '0;
            wr_q    <= 1'b0;
            flags_q <= '0;
        end else if (!halted) begin
            case (phase)
                PH_FETCH: begin
                    ir <= instr_t'(opcode);
                    dr <= data;
                end
                PH_DECODE: kind_q <= decode_code(ir.code);
                PH_READ: begin
                    opa <= rd_a;
                    opb <= rd_b;
                end
                PH_EXEC: begin
                    res_q   <= ex.value;
                    wr_q    <= ex.wr;
                    flags_q <= ex.flags;
                end
                default: wr_q <= 1'b0;
            endcase
        end
    end

    assign cond_flags = flags_q;
    assign mem_addr   = (in_wb && kind_q == K_STORE) ? dr  : 'z;
    assign mem_wdata  = (in_wb && kind_q == K_STORE) ? opa : 'z;
    assign pc_target  = (in_wb && kind_q == K_JUMP)  ? dr  : 'z;

    // R5
    flags_window_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_EXEC) |=> $stable(flags_q));
    // R13
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && kind_q == K_NOP) |=> (!wr_q && $stable(flags_q)));
endmodule

// File: tb/test_alu5_core.sv
`timescale 1ns/1ps
module test_alu5_core;
    logic        clk = 1'b0;
    logic        rst;
    logic [13:0] opcode;
    logic [15:0] data;
    wire  [15:0] mem_addr, mem_wdata, pc_target;
    wire  [3:0]  cond_flags;
    wire         halted;

    always #2 clk = ~clk;

    alu5_core i_alu5_core (
        .clk(clk), .rst(rst), .opcode(opcode), .data(data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_target(pc_target),
        .cond_flags(cond_flags), .halted(halted)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    logic [15:0] m_reg [8];
    logic [15:0] m_stk [8];
    logic [3:0]  m_flg;
    int          m_sp;
    bit          m_halt;

    logic [15:0] s_addr, s_wdata, s_pc;
    logic [3:0]  s_flg;
    bit          s_quiet;

    // a two-state simulator may show an undriven net as zero
    function automatic bit rel(input logic [15:0] v);
        return (v === 16'hzzzz) || (v === 16'h0000);
    endfunction

    function automatic bit all_rel();
        return rel(mem_addr) && rel(mem_wdata) && rel(pc_target);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin m_reg[i] = 0; m_stk[i] = 0; end
        m_flg = 0; m_sp = 0; m_halt = 0;
    endtask

    task automatic model(input logic [7:0] c, input logic [2:0] a, input logic [2:0] b, input logic [15:0] d);
        logic [16:0] s;
        logic [31:0] p;
        logic [15:0] r;
        if (m_halt) return;
        case (c)
            8'h01: m_reg[a] = m_reg[a] & m_reg[b];
            8'h02: m_reg[a] = m_reg[a] | m_reg[b];
            8'h03: m_reg[a] = m_reg[a] ^ m_reg[b];
            8'h04: m_reg[a] = ~m_reg[a];
            8'h05: begin
                r = 16'h0 - m_reg[a];
                m_flg = {r == 0, m_reg[a] != 0, r[15], m_reg[a] == 16'h8000};
                m_reg[a] = r;
            end
            8'h06: begin
                s = {1'b0, m_reg[a]} + {1'b0, m_reg[b]};
                m_flg = {s[15:0] == 0, s[16], s[15],
                         (m_reg[a][15] == m_reg[b][15]) && (s[15] != m_reg[a][15])};
                m_reg[a] = s[15:0];
            end
            8'h07: begin
                p = m_reg[a] * m_reg[b];
                m_flg = {p[15:0] == 0, p[31:16] != 0, p[15], p[31:16] != 0};
                m_reg[a] = p[15:0];
            end
            8'h08: m_reg[a] = d;
            8'h09: if (m_sp < 8) begin m_stk[m_sp] = m_reg[a]; m_sp++; end
            8'h0A: if (m_sp > 0) begin m_sp--; m_reg[a] = m_stk[m_sp]; end
            8'h0D: m_halt = 1;
            default: ;
        endcase
    endtask

    // called at a negedge just before a fetch edge; returns at the next such negedge
    task automatic issue(input logic [7:0] c, input logic [2:0] a, input logic [2:0] b, input logic [15:0] d);
        opcode = {c, a, b};
        data   = d;
        s_quiet = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (!all_rel()) s_quiet = 0;
        end
        @(negedge clk);
        s_addr = mem_addr; s_wdata = mem_wdata; s_pc = pc_target; s_flg = cond_flags;
        @(negedge clk);
        if (!all_rel()) s_quiet = 0;
        model(c, a, b, d);
    endtask

    task automatic chk_reg(input logic [2:0] r, input string req);
        logic [15:0] ad;
        ad = 16'h4000 | {13'h0, r} | 16'h0100;
        issue(8'h0B, r, 3'd0, ad);
        check(s_wdata === m_reg[r], req, {16'h0, s_wdata}, {16'h0, m_reg[r]});
    endtask

    task automatic chk_flags(input string req);
        check(s_flg === m_flg, req, {28'h0, s_flg}, {28'h0, m_flg});
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [7];
        logic [15:0] pre;
        int unsigned seed;
        ops = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
        seed = $urandom(32'd4242);
        rst = 1; opcode = 0; data = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        check(cond_flags === 4'h0, "R12 flags", {28'h0, cond_flags}, 0);
        check(halted === 1'b0, "R12 halted", {31'h0, halted}, 0);
        check(all_rel(), "R12 buses released", {16'h0, mem_addr}, 0);
        chk_reg(3'd5, "R12 register cleared");

        // R3 load every register, read back
        for (int i = 0; i < 8; i++) issue(8'h08, 3'(i), 3'd0, 16'h1111 * 16'(i + 1) ^ 16'h0F0F);
        for (int i = 0; i < 8; i++) chk_reg(3'(i), "R3 load-immediate");

        // R9 / R1 store timing and bus values
        issue(8'h0B, 3'd2, 3'd0, 16'hBEEF);
        check(s_addr === 16'hBEEF, "R9 store address", {16'h0, s_addr}, 32'hBEEF);
        check(s_wdata === m_reg[2], "R9 store data", {16'h0, s_wdata}, {16'h0, m_reg[2]});
        check(rel(s_pc), "R10 pc released on store", {16'h0, s_pc}, 0);
        check(s_quiet, "R1 buses only in write-back", {31'h0, s_quiet}, 1);

        // R10 jump
        issue(8'h0C, 3'd0, 3'd0, 16'h3A5C);
        check(s_pc === 16'h3A5C, "R10 jump target", {16'h0, s_pc}, 32'h3A5C);
        check(rel(s_addr) && rel(s_wdata), "R9 memory released on jump", {16'h0, s_addr}, 0);
        check(s_quiet, "R10 pc only in write-back", {31'h0, s_quiet}, 1);

        // R4 logic ops, flags held
        issue(8'h06, 3'd0, 3'd0, 0);  // set some flags first
        pre = {12'h0, m_flg};
        issue(8'h01, 3'd1, 3'd2, 0); chk_flags("R4 flags unchanged");
        chk_reg(3'd1, "R4 AND");
        issue(8'h02, 3'd3, 3'd4, 0); chk_reg(3'd3, "R4 OR");
        issue(8'h03, 3'd5, 3'd6, 0); chk_reg(3'd5, "R4 XOR");
        issue(8'h04, 3'd7, 3'd0, 0); chk_reg(3'd7, "R4 NOT");
        check(m_flg == pre[3:0], "R4 model flags held", {28'h0, m_flg}, pre);

        // R5 / R2 add corners
        issue(8'h08, 3'd5, 3'd0, 16'h7FFF); issue(8'h08, 3'd2, 3'd0, 16'h0001);
        issue(8'h06, 3'd5, 3'd2, 0);
        check(s_flg === 4'b0011, "R5 add signed overflow", {28'h0, s_flg}, 4'b0011);
        chk_reg(3'd5, "R2 register fields");
        issue(8'h08, 3'd6, 3'd0, 16'hFFFF);
        issue(8'h06, 3'd6, 3'd2, 0);
        check(s_flg === 4'b1100, "R5 add carry to zero", {28'h0, s_flg}, 4'b1100);
        issue(8'h08, 3'd4, 3'd0, 16'h8000);
        issue(8'h05, 3'd4, 3'd0, 0);
        check(s_flg === 4'b0111, "R5 neg most negative", {28'h0, s_flg}, 4'b0111);
        issue(8'h05, 3'd6, 3'd0, 0);
        check(s_flg === 4'b1000, "R5 neg zero", {28'h0, s_flg}, 4'b1000);

        // R6 multiply
        issue(8'h08, 3'd1, 3'd0, 16'h0123); issue(8'h08, 3'd3, 3'd0, 16'h0456);
        issue(8'h07, 3'd1, 3'd3, 0); chk_flags("R6 mul wide flags");
        chk_reg(3'd1, "R6 mul low half");
        issue(8'h08, 3'd1, 3'd0, 16'h0012); issue(8'h08, 3'd3, 3'd0, 16'h0034);
        issue(8'h07, 3'd1, 3'd3, 0);
        check(s_flg === 4'b0000, "R6 mul narrow flags", {28'h0, s_flg}, 0);

        // R14 read right after write
        issue(8'h08, 3'd2, 3'd0, 16'h2222);
        issue(8'h06, 3'd0, 3'd2, 0);
        chk_reg(3'd0, "R14 read-after-write");

        // random arithmetic and logic mix
        for (int i = 0; i < 40; i++) begin
            logic [7:0] c; logic [2:0] a, b;
            c = ops[$urandom_range(0, 6)]; a = 3'($urandom); b = 3'($urandom);
            if (i % 5 == 0) issue(8'h08, b, 3'd0, 16'($urandom));
            issue(c, a, b, 0);
            chk_flags(c >= 8'h05 ? "R5 R6 random flags" : "R4 random flags");
            chk_reg(a, c == 8'h07 ? "R6 random" : (c >= 8'h05 ? "R5 random" : "R4 random"));
        end

        // R7 / R8 stack
        for (int i = 0; i < 9; i++) begin
            issue(8'h08, 3'd1, 3'd0, 16'hA000 + 16'(i));
            issue(8'h09, 3'd1, 3'd0, 0);
        end
        issue(8'h08, 3'd2, 3'd0, 16'h5555);
        for (int i = 0; i < 8; i++) begin
            issue(8'h0A, 3'd2, 3'd0, 0);
            chk_reg(3'd2, "R7 pop order");
        end
        check(m_reg[2] === 16'hA000, "R8 ninth push dropped", {16'h0, m_reg[2]}, 32'hA000);
        issue(8'h08, 3'd2, 3'd0, 16'h6666);
        issue(8'h0A, 3'd2, 3'd0, 0);
        chk_reg(3'd2, "R8 pop empty keeps register");
        issue(8'h09, 3'd2, 3'd0, 0); issue(8'h0A, 3'd7, 3'd0, 0);
        chk_reg(3'd7, "R8 stack usable after underflow");

        // R13 undefined codes
        pre = {12'h0, s_flg};
        issue(8'hEE, 3'd7, 3'd1, 16'hFFFF);
        check(s_flg === m_flg, "R13 flags unchanged", {28'h0, s_flg}, {28'h0, m_flg});
        check(s_quiet && rel(s_addr) && rel(s_pc), "R13 buses released", {16'h0, s_addr}, 0);
        for (int i = 0; i < 8; i++) chk_reg(3'(i), "R13 registers unchanged");

        // R11 halt
        issue(8'h08, 3'd4, 3'd0, 16'h9ABC);
        issue(8'h0D, 3'd0, 3'd0, 0);
        check(halted === 1'b1, "R11 halted set", {31'h0, halted}, 1);
        issue(8'h0B, 3'd4, 3'd0, 16'h7777);
        check(rel(s_addr) && rel(s_wdata) && s_quiet, "R11 no store after halt", {16'h0, s_wdata}, 0);
        issue(8'h0C, 3'd0, 3'd0, 16'h1234);
        check(rel(s_pc), "R11 no jump after halt", {16'h0, s_pc}, 0);
        issue(8'h06, 3'd4, 3'd4, 0);
        check(cond_flags === m_flg, "R11 flags frozen", {28'h0, cond_flags}, {28'h0, m_flg});

        // R12 reset after halt
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
        check(halted === 1'b0, "R12 halt cleared", {31'h0, halted}, 0);
        check(cond_flags === 4'h0, "R12 flags cleared", {28'h0, cond_flags}, 0);
        chk_reg(3'd4, "R12 registers cleared");
        issue(8'h0A, 3'd4, 3'd0, 0);
        chk_reg(3'd4, "R12 stack cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule